// File: doc/BRIEF.md
# Ternary Operand Modifier Stage

This stage conditions one operand on its way from a register read port to an execution unit. The operand is a word of balanced-ternary trits, each held in two bits. A small signed modifier field, itself a balanced-ternary number, chooses what happens to the word. A handful of values at the most negative end of the modifier range pick a tritwise unary map: sign flip, cyclic step up, cyclic step down, absolute value, negated absolute value, or clearing of negative trits. Signed values whose magnitude is below the word length shift the word by that many trit places. Every other value, zero included, leaves the word as it is.

The result is registered. It is loaded only in cycles that carry a valid strobe, and a valid flag follows it one cycle later. The choice of register and the arithmetic downstream are not part of this block. The word length and the modifier width are parameters. The six map codes always sit at the most negative end of the modifier range, so the modifier must be wide enough that they do not overlap the shift codes.

Top module: `tmod_stage`

## Requirements
- R1: Each trit takes two bits, coded 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1. Trit i of a word occupies bits [2i+1:2i]. Trit i of the modifier carries weight 3^i. With the default four modifier trits this gives values from -40 to +40, where -40 has every trit at -1 (8'hFF).
- R2: Modifier -40 flips the sign of every trit (+1 and -1 swap, 0 stays 0).
- R3: Modifier -39 steps every trit cyclically up (0 to +1, +1 to -1, -1 to 0).
- R4: Modifier -38 steps every trit cyclically down (0 to -1, -1 to +1, +1 to 0).
- R5: Modifier -37 turns every -1 trit into +1. Modifier -36 turns every +1 trit into -1. All other trits are unchanged.
- R6: Modifier -35 turns every -1 trit into 0 and leaves the other trits unchanged.
- R7: Modifier +1 to +26 moves the word toward higher trit positions by that many places. Trits pushed past the top are lost and the low end fills with 0 trits.
- R8: Modifier -1 to -26 moves the word toward lower trit positions by the magnitude. Trits pushed past trit 0 are lost and the top fills with 0 trits.
- R9: Modifier 0, modifiers -34 to -27, and modifiers +27 to +40 return the operand unchanged.
- R10: In the cycle after a clock edge that sees in_valid high, out_valid is high and out_data holds the result for the operand and modifier sampled at that edge. In the cycle after an edge that sees in_valid low, out_valid is low and out_data keeps its previous value.
- R11: While rst_n is low, and until the first valid operand arrives after reset, out_valid is 0 and out_data is all zero trits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand and modifier are valid this cycle |
| in_data | input | 2*NTRITS (54) | Operand word, two bits per trit |
| in_mod | input | 2*MTRITS (8) | Modifier field, two bits per trit |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 2*NTRITS (54) | Registered modified operand |

## Verification
The bench builds the stage with its default parameters: 27 operand trits and 4 modifier trits. With these values every modifier code from -40 to +40 can be driven. This covers the boundaries between the map codes, the pass-through bands and the shift band, as well as the full-length shifts of 26 places that leave only one surviving trit. Operand patterns mix all three trit values, so each unary map is exercised on every input trit value.

// File: rtl/tmod_pkg.sv
package tmod_pkg;

  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_POS  = 2'b01;
  localparam logic [1:0] TRIT_NEG  = 2'b11;

  typedef enum logic [2:0] {
    OP_PASS  = 3'd0,
    OP_FLIP  = 3'd1,
    OP_STEPU = 3'd2,
    OP_STEPD = 3'd3,
    OP_ABS   = 3'd4,
    OP_NABS  = 3'd5,
    OP_CLRN  = 3'd6,
    OP_SHIFT = 3'd7
  } tmod_op_e;

  // Tritwise unary map; non-canonical code 2'b10 is read as zero.
  function automatic logic [1:0] map_trit(tmod_op_e op, logic [1:0] t);
    logic [1:0] tn;
    logic [1:0] r;
    tn = (t == 2'b10) ? TRIT_ZERO : t;
    r  = tn;
    case (op)
      OP_FLIP:  r = (tn == TRIT_POS) ? TRIT_NEG : (tn == TRIT_NEG) ? TRIT_POS : TRIT_ZERO;
      OP_STEPU: r = (tn == TRIT_ZERO) ? TRIT_POS : (tn == TRIT_POS) ? TRIT_NEG : TRIT_ZERO;
      OP_STEPD: r = (tn == TRIT_ZERO) ? TRIT_NEG : (tn == TRIT_NEG) ? TRIT_POS : TRIT_ZERO;
      OP_ABS:   r = (tn == TRIT_NEG) ? TRIT_POS : tn;
      OP_NABS:  r = (tn == TRIT_POS) ? TRIT_NEG : tn;
      OP_CLRN:  r = (tn == TRIT_NEG) ? TRIT_ZERO : tn;
      default:  r = t;
    endcase
    return r;
  endfunction

  // True when any trit of a word carries the given code.
  function automatic logic word_has(logic [1:0] code, logic [255:0] w, int ntrits);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < ntrits; i++) begin
      if (w[2*i +: 2] == code) hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/tmod_decode.sv
module tmod_decode
  import tmod_pkg::*;
#(
  parameter int MTRITS = 4,
  parameter int NTRITS = 27,
  parameter int AMT_W  = $clog2(NTRITS)
) (
  input  logic [2*MTRITS-1:0] mod_code,
  output tmod_op_e            op,
  output logic                shift_left,
  output logic [AMT_W-1:0]    shift_amt
);

  localparam int MAXV    = (3**MTRITS - 1) / 2;
  localparam int MAP_LO  = -MAXV;
  localparam int MAP_HI  = -MAXV + 5;
  localparam int SHMAX   = NTRITS - 1;

  int value;

  always_comb begin
    int w;
    value = 0;
    w     = 1;
    for (int i = 0; i < MTRITS; i++) begin
      case (mod_code[2*i +: 2])
        TRIT_POS: value = value + w;
        TRIT_NEG: value = value - w;
        default:  value = value;
      endcase
      w = w * 3;
    end
  end

  always_comb begin
    op         = OP_PASS;
    shift_left = 1'b0;
    shift_amt  = '0;
    if (value >= MAP_LO && value <= MAP_HI) begin
      case (value - MAP_LO)
        0:       op = OP_FLIP;
        1:       op = OP_STEPU;
        2:       op = OP_STEPD;
        3:       op = OP_ABS;
        4:       op = OP_NABS;
        default: op = OP_CLRN;
      endcase
    end else if (value != 0 && value <= SHMAX && value >= -SHMAX) begin
      op         = OP_SHIFT;
      shift_left = (value > 0);
      shift_amt  = AMT_W'((value > 0) ? value : -value);
    end
  end

endmodule

// File: rtl/tmod_tritmap.sv
module tmod_tritmap
  import tmod_pkg::*;
#(
  parameter int NTRITS = 27
) (
  input  tmod_op_e            op,
  input  logic [2*NTRITS-1:0] din,
  output logic [2*NTRITS-1:0] dout
);

  for (genvar i = 0; i < NTRITS; i++) begin : g_trit
    assign dout[2*i +: 2] = map_trit(op, din[2*i +: 2]);
  end

endmodule

// File: rtl/tmod_shift.sv
module tmod_shift #(
  parameter int NTRITS = 27,
  parameter int AMT_W  = $clog2(NTRITS)
) (
  input  logic [2*NTRITS-1:0] din,
  input  logic                left,
  input  logic [AMT_W-1:0]    amt,
  output logic [2*NTRITS-1:0] dout
);

  localparam int W = 2 * NTRITS;

  logic [W-1:0] stage [0:AMT_W];

  assign stage[0] = din;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int BITS = 2 * (1 << k);
    logic [W-1:0] moved;
    assign moved        = left ? (stage[k] << BITS) : (stage[k] >> BITS);
    assign stage[k + 1] = amt[k] ? moved : stage[k];
  end

  assign dout = stage[AMT_W];

endmodule

// File: rtl/tmod_stage.sv
module tmod_stage
  import tmod_pkg::*;
#(
  parameter int NTRITS = 27,
  parameter int MTRITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*NTRITS-1:0] in_data,
  input  logic [2*MTRITS-1:0] in_mod,
  output logic                out_valid,
  output logic [2*NTRITS-1:0] out_data
);

  localparam int W     = 2 * NTRITS;
  localparam int AMT_W = $clog2(NTRITS);

  // Reset synchronizer: asserts at once, releases on the clock.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  tmod_op_e         op;
  logic             sh_left;
  logic [AMT_W-1:0] sh_amt;
  logic [W-1:0]     mapped;
  logic [W-1:0]     shifted;

  tmod_decode #(.MTRITS(MTRITS), .NTRITS(NTRITS), .AMT_W(AMT_W)) u_decode (
    .mod_code   (in_mod),
    .op         (op),
    .shift_left (sh_left),
    .shift_amt  (sh_amt)
  );

  tmod_tritmap #(.NTRITS(NTRITS)) u_map (
    .op   (op),
    .din  (in_data),
    .dout (mapped)
  );

  tmod_shift #(.NTRITS(NTRITS), .AMT_W(AMT_W)) u_shift (
    .din  (in_data),
    .left (sh_left),
    .amt  (sh_amt),
    .dout (shifted)
  );

  // Next-state
  logic [W-1:0] res_d;
  logic         vld_d;
  logic         data_en;

  always_comb begin
    case (op)
      OP_PASS:  res_d = in_data;
      OP_SHIFT: res_d = shifted;
      default:  res_d = mapped;
    endcase
    vld_d   = in_valid;
    data_en = in_valid;
  end

  // Registers
  logic [W-1:0] res_q;
  logic         vld_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (data_en) begin
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = res_q;

  // Assertions
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (out_valid == $past(in_valid))); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_data)); // R10

  AST_PASS_KEEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_PASS) |=> (out_data == $past(in_data))); // R9

  AST_CLRN_NO_NEG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_CLRN) |=> !word_has(TRIT_NEG, 256'(out_data), NTRITS)); // R6

  AST_ABS_NO_NEG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_ABS) |=> !word_has(TRIT_NEG, 256'(out_data), NTRITS)); // R5

  AST_NABS_NO_POS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_NABS) |=> !word_has(TRIT_POS, 256'(out_data), NTRITS)); // R5

  AST_SHIFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_SHIFT && sh_left && sh_amt != '0) |=> (out_data[1:0] == TRIT_ZERO)); // R7

  AST_SHIFT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op == OP_SHIFT && !sh_left && sh_amt != '0) |=> (out_data[W-1:W-2] == TRIT_ZERO)); // R8

endmodule

// File: tb/tmod_stage_tb.sv
module tmod_stage_tb;

  localparam int N = 27;
  localparam int M = 4;
  localparam int W = 2 * N;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic [2*M-1:0] in_mod;
  logic         out_valid;
  logic [W-1:0] out_data;

  int n_checks;
  int n_fails;
  bit finished;

  tmod_stage #(.NTRITS(N), .MTRITS(M)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_mod    (in_mod),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Stimulus table: {pattern slope, pattern offset, modifier}
  localparam int NV = 18;
  localparam int VEC [0:NV-1][0:2] = '{
    '{1, 0, -40}, '{2, 1, -40}, '{1, 2, -39}, '{2, 0, -38},
    '{1, 1, -37}, '{2, 2, -36}, '{1, 0, -35}, '{1, 1, 1},
    '{2, 0, 26},  '{1, 2, 13},  '{1, 0, -1},  '{2, 1, -26},
    '{1, 1, -9},  '{1, 2, 0},   '{2, 2, -34}, '{1, 0, -27},
    '{2, 1, 27},  '{1, 1, 40}
  };

  function automatic logic [1:0] enc_trit(int t);
    return (t > 0) ? 2'b01 : (t < 0) ? 2'b11 : 2'b00;
  endfunction

  function automatic int dec_trit(logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
  endfunction

  function automatic logic [W-1:0] pattern(int a, int b);
    logic [W-1:0] w;
    for (int i = 0; i < N; i++) w[2*i +: 2] = enc_trit(((a * i + b) % 3) - 1);
    return w;
  endfunction

  function automatic logic [2*M-1:0] enc_mod(int v);
    logic [2*M-1:0] c;
    int r;
    int x;
    x = v;
    for (int i = 0; i < M; i++) begin
      r = ((x % 3) + 3) % 3;
      if (r == 2) begin c[2*i +: 2] = 2'b11; x = (x + 1) / 3; end
      else if (r == 1) begin c[2*i +: 2] = 2'b01; x = (x - 1) / 3; end
      else begin c[2*i +: 2] = 2'b00; x = x / 3; end
    end
    return c;
  endfunction

  function automatic logic [W-1:0] model(logic [W-1:0] d, int m);
    int t [N];
    int o [N];
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) t[i] = dec_trit(d[2*i +: 2]);
    for (int i = 0; i < N; i++) begin
      o[i] = t[i];
      if (m == -40) o[i] = -t[i];
      else if (m == -39) o[i] = (t[i] == 1) ? -1 : t[i] + 1;
      else if (m == -38) o[i] = (t[i] == -1) ? 1 : t[i] - 1;
      else if (m == -37) o[i] = (t[i] < 0) ? 1 : t[i];
      else if (m == -36) o[i] = (t[i] > 0) ? -1 : t[i];
      else if (m == -35) o[i] = (t[i] < 0) ? 0 : t[i];
      else if (m >= -26 && m <= 26 && m != 0)
        o[i] = (i - m >= 0 && i - m < N) ? t[i - m] : 0;
    end
    for (int i = 0; i < N; i++) r[2*i +: 2] = enc_trit(o[i]);
    return r;
  endfunction

  function automatic string req_of(int m);
    if (m == -40) return "R2";
    if (m == -39) return "R3";
    if (m == -38) return "R4";
    if (m == -37 || m == -36) return "R5";
    if (m == -35) return "R6";
    if (m >= 1 && m <= 26) return "R7";
    if (m <= -1 && m >= -26) return "R8";
    return "R9";
  endfunction

  task automatic check_data(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: out_data actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: out_valid actual %b expected %b", req, got, exp);
    end
  endtask

  // Drive one operand at a falling edge, check one cycle later.
  task automatic apply(logic [W-1:0] d, int m);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_mod   = enc_mod(m);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R10", out_valid, 1'b1);
    check_data(req_of(m), out_data, model(d, m));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] held;
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    in_mod   = '0;

    // R11: reset state, including with valid driven during reset
    repeat (3) @(negedge clk);
    in_valid = 1'b1;
    in_data  = pattern(1, 0);
    @(negedge clk);
    check_bit("R11", out_valid, 1'b0);
    check_data("R11", out_data, '0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R11", out_valid, 1'b0);
    check_data("R11", out_data, '0);

    // R1: encoding of the extreme modifier 8'hFF is -40 (sign flip)
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = pattern(1, 0);
    in_mod   = 8'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    check_data("R1", out_data, model(pattern(1, 0), -40));

    // Table walk
    for (int v = 0; v < NV; v++) apply(pattern(VEC[v][0], VEC[v][1]), VEC[v][2]);

    // Full modifier sweep on a mixed pattern
    for (int m = -40; m <= 40; m++) apply(pattern(2, 1), m);

    // R7/R8 boundaries: all +1 word shifted by the full length
    d = '0;
    for (int i = 0; i < N; i++) d[2*i +: 2] = 2'b01;
    apply(d, 26);
    check_data("R7", out_data, {2'b01, {(W-2){1'b0}}});
    apply(d, -26);
    check_data("R8", out_data, {{(W-2){1'b0}}, 2'b01});

    // R10: idle cycles keep the result and drop valid
    held = out_data;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = pattern(1, 1);
    in_mod   = enc_mod(0);
    @(negedge clk);
    check_bit("R10", out_valid, 1'b0);
    check_data("R10", out_data, held);

    // R10: back-to-back operands
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = pattern(1, 2);
    in_mod   = enc_mod(-40);
    @(negedge clk);
    check_data("R10", out_data, model(pattern(1, 2), -40));
    in_data = pattern(2, 0);
    in_mod  = enc_mod(5);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R10", out_valid, 1'b1);
    check_data("R10", out_data, model(pattern(2, 0), 5));

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule